// File: doc/BRIEF.md
# Reset Source Controller with Cause Register

This block merges four internal reset requests and the power-on reset into a single system reset pulse of fixed length. The four internal sources are a synchronized comparator result, a watchdog timeout, a flash access error strobe and a software trigger. After each reset, a readable cause register shows which single source produced the most recent reset. Software starts a reset, and enables the comparator as a reset source, by writing 1s into that same register.

The comparator source is off after power-on. Software must enable it. Once enabled, the source is held off for a settle window, and only then can a low compare result start a reset. A second register holds the watchdog enable and the watchdog clock select. Every reset returns this register to its default: watchdog enabled, clocked from the system clock divided by 12. None of the internal resets drives an external reset pin; the block has no such output.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1. After `rst_ni` is released, `sys_rst_o` stays 1 for 16 more cycles. The cause register (address 0) then reads 0x02, with bit 1 as the power-on flag.
- R2: Every reset pulse on `sys_rst_o` lasts exactly RST_CYC (16) clock cycles.
- R3: Writing address 0 with bit 4 set starts a reset on the next cycle. Afterwards address 0 reads 0x10.
- R4: A cycle with `wdt_timeout_i` high starts a reset. Afterwards address 0 reads 0x08 (bit 3).
- R5: A cycle with `flash_err_i` high starts a reset. Afterwards address 0 reads 0x40 (bit 6).
- R6: After power-on the comparator source is disabled, and a low `cmp_i` has no effect.
- R7: Writing 1 to bit 5 of address 0 enables the comparator source, and writing 0 there does not disable it. The enable survives every internal reset and is cleared only by power-on reset. Once settled, a low `cmp_i` starts a reset on the third rising edge after it is driven.
- R8: The enable takes effect only after a settle window of SETTLE_CYC (8) cycles. With `cmp_i` held low from the write onward, the reset starts on the ninth rising edge after the write edge. Afterwards address 0 reads 0x20 (bit 5).
- R9: When several sources request in the same cycle, the cause follows the priority flash error > watchdog > comparator > software.
- R10: Exactly one cause flag is set at any time after reset.
- R11: Address 1 holds the watchdog enable in bit 0 and the clock select in bits 2:1, where 00 means system clock divided by 12. This register is writable, and every reset restores it to 0x01.
- R12: Register writes and reset requests are ignored while `sys_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 cause/trigger, 1 watchdog control |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| cmp_i | input | 1 | Comparator result, 1 when the non-inverting input is above the inverting input |
| wdt_timeout_i | input | 1 | Watchdog timeout request |
| flash_err_i | input | 1 | Flash access error strobe |
| sys_rst_o | output | 1 | Stretched system reset, active high |
| wdt_en_o | output | 1 | Watchdog enable |
| wdt_clk_sel_o | output | 2 | Watchdog clock select, 00 = system clock / 12 |

## Verification
The assertions check properties that must hold on every cycle:
- the exact pulse length;
- a single cause flag;
- a software write being followed by a reset;
- flash precedence at the start of a pulse;
- a comparator cause only from an armed source;
- watchdog defaults at the end of every pulse;
- watchdog control staying stable under writes during reset.

Other behaviours show only over a sequence of operations, and the bench's scenarios cover them:
- the exact arrival cycle after the settle window and after the synchronizer;
- the enable surviving an internal reset but not a power-on reset;
- a disabled comparator staying harmless;
- requests made during a pulse being lost.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;

  localparam logic [ADDR_W-1:0] ADDR_CAUSE = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_WDT   = 1'b1;

  localparam int BIT_POR   = 1;
  localparam int BIT_WDT   = 3;
  localparam int BIT_SW    = 4;
  localparam int BIT_CMP   = 5;
  localparam int BIT_FLASH = 6;
  localparam int BIT_WEN   = 0;
  localparam int BIT_WSEL  = 1;

  typedef enum logic [1:0] {
    WDT_DIV12  = 2'b00,
    WDT_DIV4   = 2'b01,
    WDT_SYSCLK = 2'b10,
    WDT_ALT    = 2'b11
  } wdt_clk_e;

  // field order is the priority order, highest first
  typedef struct packed {
    logic flash;
    logic wdt;
    logic cmp;
    logic sw;
  } req_t;

  typedef struct packed {
    logic por;
    logic flash;
    logic wdt;
    logic cmp;
    logic sw;
  } cause_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcc_arm.sv
module rcc_arm #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic en_o,
  output logic armed_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic          en_q;
  logic [SW-1:0] settle_q;

  // enable is sticky: only power-on clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      settle_q <= SW'(SETTLE_CYC);
    end else begin
      if (set_i) en_q <= 1'b1;
      if (en_q && settle_q != '0) settle_q <= settle_q - 1'b1;
    end
  end

  assign en_o    = en_q;
  assign armed_o = en_q && (settle_q == '0);
endmodule

// File: rtl/rcc_prio.sv
module rcc_prio
  import rcc_pkg::*;
(
  input  req_t   req_i,
  output logic   fire_o,
  output cause_t cause_o
);
  always_comb begin
    cause_o = '0;
    if      (req_i.flash) cause_o.flash = 1'b1;
    else if (req_i.wdt)   cause_o.wdt   = 1'b1;
    else if (req_i.cmp)   cause_o.cmp   = 1'b1;
    else if (req_i.sw)    cause_o.sw    = 1'b1;
  end

  assign fire_o = |req_i;
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(RST_CYC - 1);
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(RST_CYC - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int RST_CYC    = 16,
  parameter int SETTLE_CYC = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cmp_i,
  input  logic              wdt_timeout_i,
  input  logic              flash_err_i,
  output logic              sys_rst_o,
  output logic              wdt_en_o,
  output logic [1:0]        wdt_clk_sel_o
);
  logic     rst_active;
  logic     cmp_sync, cmp_en, cmp_armed;
  logic     wr_cause, wr_wdt, fire;
  req_t     req;
  cause_t   cause_q, cause_nxt;
  logic     wdt_en_q;
  wdt_clk_e wdt_sel_q;

  assign wr_cause = wr_en_i && !rst_active && (addr_i == ADDR_CAUSE);
  assign wr_wdt   = wr_en_i && !rst_active && (addr_i == ADDR_WDT);

  rcc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_sync)
  );

  rcc_arm #(.SETTLE_CYC(SETTLE_CYC)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr_cause && wr_data_i[BIT_CMP]),
    .en_o    (cmp_en),
    .armed_o (cmp_armed)
  );

  always_comb begin
    req       = '0;
    if (!rst_active) begin
      req.flash = flash_err_i;
      req.wdt   = wdt_timeout_i;
      req.cmp   = cmp_armed && !cmp_sync;  // low result = below threshold
      req.sw    = wr_cause && wr_data_i[BIT_SW];
    end
  end

  rcc_prio u_prio (
    .req_i   (req),
    .fire_o  (fire),
    .cause_o (cause_nxt)
  );

  rcc_stretch #(.RST_CYC(RST_CYC)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fire),
    .active_o (rst_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q     <= '0;
      cause_q.por <= 1'b1;
    end else if (fire) begin
      cause_q <= cause_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_en_q  <= 1'b1;
      wdt_sel_q <= WDT_DIV12;
    end else if (fire) begin
      wdt_en_q  <= 1'b1;
      wdt_sel_q <= WDT_DIV12;
    end else if (wr_wdt) begin
      wdt_en_q  <= wr_data_i[BIT_WEN];
      wdt_sel_q <= wdt_clk_e'(wr_data_i[BIT_WSEL+:2]);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_CAUSE) begin
      rd_data_o[BIT_POR]   = cause_q.por;
      rd_data_o[BIT_WDT]   = cause_q.wdt;
      rd_data_o[BIT_SW]    = cause_q.sw;
      rd_data_o[BIT_CMP]   = cause_q.cmp;
      rd_data_o[BIT_FLASH] = cause_q.flash;
    end else begin
      rd_data_o[BIT_WEN]        = wdt_en_q;
      rd_data_o[BIT_WSEL+:2]    = wdt_sel_q;
    end
  end

  assign sys_rst_o     = rst_active;
  assign wdt_en_o      = wdt_en_q;
  assign wdt_clk_sel_o = wdt_sel_q;

  logic unused_en;
  assign unused_en = cmp_en;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              flash_err_i,
  input logic              sys_rst_o,
  input logic              wdt_en_o,
  input logic [1:0]        wdt_clk_sel_o,
  input logic [4:0]        cause_i,
  input logic              cmp_armed_i,
  input logic              cmp_sync_i
);
  localparam int HW = $clog2(RST_CYC + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else         hi_cnt <= sys_rst_o ? hi_cnt + 1'b1 : '0;
  end

  assert_pulse_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_cnt == HW'(RST_CYC));

  assert_one_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cause_i) == 1);

  assert_sw_trigger_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && wr_en_i && addr_i == ADDR_CAUSE && wr_data_i[BIT_SW]) |=> sys_rst_o);

  assert_flash_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && $past(flash_err_i)) |-> cause_i[3]);

  assert_cmp_armed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && cause_i[1]) |-> $past(cmp_armed_i && !cmp_sync_i));

  assert_wdt_default_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (wdt_en_o && wdt_clk_sel_o == 2'b00));

  assert_hold_in_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && wr_en_i) |=> $stable({wdt_en_o, wdt_clk_sel_o}));
endmodule

bind rst_cause_ctrl rcc_checker #(.RST_CYC(RST_CYC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wr_data_i     (wr_data_i),
  .flash_err_i   (flash_err_i),
  .sys_rst_o     (sys_rst_o),
  .wdt_en_o      (wdt_en_o),
  .wdt_clk_sel_o (wdt_clk_sel_o),
  .cause_i       (cause_q),
  .cmp_armed_i   (cmp_armed),
  .cmp_sync_i    (cmp_sync)
);

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_ni = 0;
  logic       wr_en_i = 0, addr_i = 0;
  logic [7:0] wr_data_i = 0, rd_data_o;
  logic       cmp_i = 1, wdt_timeout_i = 0, flash_err_i = 0;
  logic       sys_rst_o, wdt_en_o;
  logic [1:0] wdt_clk_sel_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cmp_i(cmp_i),
    .wdt_timeout_i(wdt_timeout_i), .flash_err_i(flash_err_i),
    .sys_rst_o(sys_rst_o), .wdt_en_o(wdt_en_o), .wdt_clk_sel_o(wdt_clk_sel_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 0; wr_data_i = 0;
  endtask

  // counts negedges with reset high, ends on first negedge with it low
  task automatic rst_len(output int n);
    n = 0;
    while (sys_rst_o && n < 40) begin n++; @(negedge clk); end
  endtask

  task automatic wait_high(output int n);
    n = 0;
    while (!sys_rst_o && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic t_por;
    logic [7:0] d; int n;
    repeat (3) @(negedge clk);
    chk("R1 reset held", sys_rst_o, 1);
    rst_ni = 1;
    rst_len(n);
    chk("R1 post-release length", n, 16);
    rd(0, d); chk("R1 cause", d, 8'h02);
    rd(1, d); chk("R11 wdt default", d, 8'h01);
  endtask

  task automatic t_wdt_ctrl;
    logic [7:0] d;
    wr(1, 8'h05);
    rd(1, d); chk("R11 wdt write", d, 8'h05);
    chk("R11 wdt_clk_sel_o", wdt_clk_sel_o, 2'b10);
  endtask

  task automatic t_sw;
    logic [7:0] d; int n;
    wr(0, 8'h10);
    rst_len(n); chk("R2 sw length", n, 16);
    rd(0, d); chk("R3 sw cause", d, 8'h10);
    rd(1, d); chk("R11 restored", d, 8'h01);
  endtask

  task automatic pulse_req(input bit fl, input bit wd);
    @(negedge clk); flash_err_i = fl; wdt_timeout_i = wd;
    @(negedge clk); flash_err_i = 0; wdt_timeout_i = 0;
  endtask

  task automatic t_wdt;
    logic [7:0] d; int n;
    wr(1, 8'h04);
    pulse_req(0, 1);
    rst_len(n); chk("R2 wdt length", n, 16);
    rd(0, d); chk("R4 wdt cause", d, 8'h08);
    chk("R11 wdt_en_o", wdt_en_o, 1);
  endtask

  task automatic t_flash;
    logic [7:0] d; int n;
    pulse_req(1, 0);
    rst_len(n);
    rd(0, d); chk("R5 flash cause", d, 8'h40);
  endtask

  task automatic t_cmp_off;
    logic [7:0] d; int hits = 0;
    cmp_i = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); hits += sys_rst_o; end
    cmp_i = 1;
    chk("R6 disabled comparator", hits, 0);
    rd(0, d); chk("R6 cause unchanged", d, 8'h40);
  endtask

  task automatic t_prio;
    logic [7:0] d; int n;
    pulse_req(1, 1);
    rst_len(n);
    rd(0, d); chk("R9 flash over wdt", d, 8'h40);
    @(negedge clk); wr_en_i = 1; addr_i = 0; wr_data_i = 8'h10; wdt_timeout_i = 1;
    @(negedge clk); wr_en_i = 0; wr_data_i = 0; wdt_timeout_i = 0;
    rst_len(n);
    rd(0, d); chk("R9 wdt over sw", d, 8'h08);
  endtask

  task automatic t_ignore;
    logic [7:0] d; int n; int hits = 0;
    wr(0, 8'h10);
    @(negedge clk); wr_en_i = 1; addr_i = 1; wr_data_i = 8'h04; flash_err_i = 1;
    @(negedge clk); wr_en_i = 0; wr_data_i = 0; flash_err_i = 0;
    rst_len(n);
    for (int i = 0; i < 4; i++) begin @(negedge clk); hits += sys_rst_o; end
    chk("R12 no second reset", hits, 0);
    rd(0, d); chk("R12 cause kept", d, 8'h10);
    rd(1, d); chk("R12 write dropped", d, 8'h01);
  endtask

  task automatic t_cmp_on;
    logic [7:0] d; int n;
    @(negedge clk); wr_en_i = 1; addr_i = 0; wr_data_i = 8'h20; cmp_i = 0;
    @(negedge clk); wr_en_i = 0; wr_data_i = 0;
    wait_high(n); cmp_i = 1;
    chk("R8 settle delay", n, 9);
    rst_len(n);
    rd(0, d); chk("R8 cmp cause", d, 8'h20);
    wr(0, 8'h00);
    wr(0, 8'h10);
    rst_len(n);
    @(negedge clk); cmp_i = 0;
    wait_high(n); cmp_i = 1;
    chk("R7 enable kept, sync latency", n, 3);
    rst_len(n);
    rd(0, d); chk("R7 cmp cause again", d, 8'h20);
  endtask

  task automatic t_por_clear;
    logic [7:0] d; int n; int hits = 0;
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    rst_len(n);
    cmp_i = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); hits += sys_rst_o; end
    cmp_i = 1;
    chk("R7 power-on clears enable", hits, 0);
    rd(0, d); chk("R1 cause after power-on", d, 8'h02);
  endtask

  initial begin
    t_por();
    t_wdt_ctrl();
    t_sw();
    t_wdt();
    t_flash();
    t_cmp_off();
    t_prio();
    t_ignore();
    t_cmp_on();
    t_por_clear();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule